// File: doc/BRIEF.md
# Selectable Clock Output Generator

This block drives a divided copy of one of two system clocks onto a pin that is otherwise ordinary general-purpose I/O. An 8-bit configuration register picks the source (crystal or bus) and a ratio (off, divide by 1, 2 or 4). While a ratio is selected, the pin leaves port control and carries the generated clock. The port's data-direction bit then works as the clock's output enable. When the ratio is off, the port's data and direction pass straight through to the pin.

Everything runs in one clock domain. Each source clock is presented as a single-cycle enable strobe, and each strobe marks one half-period of that source. The divider is a small counter that toggles the output every 1, 2 or 4 strobes of the selected source, which gives a 50% duty cycle. Whenever the source or the ratio changes, the divider restarts from a low output, so the pin never shows a stretched or clipped pulse.

Two reset inputs are provided. Power-on reset clears the whole register. General reset clears every bit except one peripheral enable, which only a power-on reset can clear. A further register bit is passed out as the enable for an extra divide-by-128 stage in a downstream timebase.

Top module: `clkout_gen`

## Requirements
- R1: While `por` is high, the register is loaded with 0x01, so it reads 0x01 and `periph_en` is 0.
- R2: A `rst` pulse without `por` loads 0x01 into every bit except bit 3 (the peripheral enable), which keeps its value.
- R3: A write stores bits 6:0 of `reg_wdata`. Bit 7 always reads 0, and `reg_rdata` shows the stored value in the cycle after the write.
- R4: Bit 6 selects the source. 1 counts `xtal_tick` strobes, 0 counts `bus_tick` strobes, and strobes of the other source leave the output unchanged.
- R5: Bits 5:4 set the ratio. 01 toggles the output on every selected strobe, 10 on every second strobe and 11 on every fourth. The output starts low, so after k strobes it equals (k / n) mod 2, where n is 1, 2 or 4.
- R6: While bits 5:4 are nonzero, `pin_out` carries the generated clock and `pin_oe` follows `gpio_ddr`. A clear direction bit holds `pin_oe` low.
- R7: While bits 5:4 are 00, `pin_out` equals `gpio_dout`, `pin_oe` equals `gpio_ddr`, and strobes have no effect on the pin.
- R8: Any change of bits 6:4 clears the divider. The generated clock is low one cycle after the register update, and counting restarts from zero.
- R9: `tbm_prescale_en` reflects bit 2 and `periph_en` reflects bit 3 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| rst | input | 1 | General reset, active high, synchronous |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (bit 7 is always 0) |
| xtal_tick | input | 1 | Crystal-source enable strobe, one per half-period |
| bus_tick | input | 1 | Bus-source enable strobe, one per half-period |
| gpio_dout | input | 1 | Port data for the shared pin |
| gpio_ddr | input | 1 | Port data-direction bit for the shared pin |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| periph_en | output | 1 | Peripheral enable, cleared by power-on reset only |
| tbm_prescale_en | output | 1 | Enable for the extra timebase prescaler |

## Verification
The bench interleaves strobes of the unselected source with the selected ones. A swapped source multiplexer would then toggle the pin on the wrong strobe. It runs each ratio over several periods from a fresh start, which catches an off-by-one in the toggle mask as a shifted or uneven waveform. It switches the ratio while the output is high, so a design that did not restart the divider would leave the pin high or produce a short pulse. It also issues a general reset after setting every bit, and a design that cleared the power-on-only enable would read back 0x01 instead of 0x09.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int CFG_W     = 8;
    localparam int DIV_CNT_W = 2;

    // Register bit positions (software visible layout)
    localparam int B_SRC      = 6;
    localparam int B_DIV_HI   = 5;
    localparam int B_DIV_LO   = 4;
    localparam int B_PERIPH   = 3;
    localparam int B_TBM      = 2;

    localparam logic [CFG_W-1:0] CFG_RESET     = 8'h01;
    localparam logic [CFG_W-1:0] CFG_POR_ONLY  = 8'h08;
    localparam logic [CFG_W-1:0] CFG_IMPL_MASK = 8'h7F;

    typedef enum logic [1:0] {
        DIV_OFF = 2'b00,
        DIV_1   = 2'b01,
        DIV_2   = 2'b10,
        DIV_4   = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic     src_xtal;
        div_sel_e div;
    } clk_mode_t;

    typedef struct packed {
        logic [DIV_CNT_W-1:0] cnt;
        logic                 out;
        clk_mode_t            mode;
    } div_state_t;

endpackage

// File: rtl/clkout_cfg_reg.sv
module clkout_cfg_reg
    import clkout_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET,
    parameter logic [CFG_W-1:0] POR_MASK  = CFG_POR_ONLY,
    parameter logic [CFG_W-1:0] IMPL_MASK = CFG_IMPL_MASK
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_o
);

    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = wdata & IMPL_MASK;
        end
        if (rst) begin
            cfg_d = (RESET_VAL & ~POR_MASK) | (cfg_q & POR_MASK);
        end
        if (por) begin
            cfg_d = RESET_VAL;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q & IMPL_MASK;

endmodule

// File: rtl/clkout_div.sv
module clkout_div
    import clkout_pkg::*;
(
    input  logic      clk,
    input  logic      rst_i,
    input  clk_mode_t mode_i,
    input  logic      tick_i,
    output logic      clk_o
);

    div_state_t           st_d, st_q;
    logic [DIV_CNT_W-1:0] mask;

    always_comb begin
        unique case (mode_i.div)
            DIV_1:   mask = DIV_CNT_W'(0);
            DIV_2:   mask = DIV_CNT_W'(1);
            DIV_4:   mask = DIV_CNT_W'(3);
            default: mask = DIV_CNT_W'(0);
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        if ((mode_i != st_q.mode) || (mode_i.div == DIV_OFF)) begin
            st_d.cnt = '0;
            st_d.out = 1'b0;
        end else if (tick_i) begin
            if ((st_q.cnt & mask) == mask) begin
                st_d.out = ~st_q.out;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign clk_o = st_q.out;

endmodule

// File: rtl/clkout_pinmux.sv
module clkout_pinmux (
    input  logic clk_mode_i,
    input  logic div_clk_i,
    input  logic ddr_i,
    input  logic dout_i,
    output logic pin_out_o,
    output logic pin_oe_o
);

    always_comb begin
        if (clk_mode_i) begin
            pin_out_o = div_clk_i;
            pin_oe_o  = ddr_i;
        end else begin
            pin_out_o = dout_i;
            pin_oe_o  = ddr_i;
        end
    end

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [CFG_W-1:0] reg_wdata,
    output logic [CFG_W-1:0] reg_rdata,
    input  logic             xtal_tick,
    input  logic             bus_tick,
    input  logic             gpio_dout,
    input  logic             gpio_ddr,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             periph_en,
    output logic             tbm_prescale_en
);

    logic [CFG_W-1:0] cfg;
    clk_mode_t        mode;
    logic             src_tick;
    logic             div_clk;

    clkout_cfg_reg u_cfg (
        .clk   (clk),
        .por   (por),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg_o (cfg)
    );

    always_comb begin
        mode.src_xtal = cfg[B_SRC];
        mode.div      = div_sel_e'(cfg[B_DIV_HI:B_DIV_LO]);
        src_tick      = mode.src_xtal ? xtal_tick : bus_tick;
    end

    clkout_div u_div (
        .clk    (clk),
        .rst_i  (por | rst),
        .mode_i (mode),
        .tick_i (src_tick),
        .clk_o  (div_clk)
    );

    clkout_pinmux u_mux (
        .clk_mode_i (mode.div != DIV_OFF),
        .div_clk_i  (div_clk),
        .ddr_i      (gpio_ddr),
        .dout_i     (gpio_dout),
        .pin_out_o  (pin_out),
        .pin_oe_o   (pin_oe)
    );

    assign reg_rdata       = cfg;
    assign periph_en       = cfg[B_PERIPH];
    assign tbm_prescale_en = cfg[B_TBM];

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
    input logic       clk,
    input logic       por,
    input logic       rst,
    input logic [7:0] reg_rdata,
    input logic       xtal_tick,
    input logic       bus_tick,
    input logic       gpio_dout,
    input logic       gpio_ddr,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       tbm_prescale_en,
    input logic       periph_en,
    input logic       clk_div
);

    logic sel_tick;
    assign sel_tick = reg_rdata[6] ? xtal_tick : bus_tick;

    a_r3_msb_zero: assert property (@(posedge clk) disable iff (por)
        reg_rdata[7] == 1'b0);

    a_r6_ddr_gates: assert property (@(posedge clk) disable iff (por)
        (reg_rdata[5:4] != 2'b00) |-> (pin_oe == gpio_ddr && pin_out == clk_div));

    a_r7_passthrough: assert property (@(posedge clk) disable iff (por)
        (reg_rdata[5:4] == 2'b00) |-> (pin_out == gpio_dout && pin_oe == gpio_ddr));

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (por || rst)
        (!sel_tick && $stable(reg_rdata[6:4])) |=> $stable(clk_div));

    a_r8_change_clears: assert property (@(posedge clk) disable iff (por || rst)
        !$stable(reg_rdata[6:4]) |=> !clk_div);

    a_r9_outputs_follow: assert property (@(posedge clk) disable iff (por)
        (tbm_prescale_en == reg_rdata[2]) && (periph_en == reg_rdata[3]));

endmodule

bind clkout_gen clkout_gen_chk u_chk (
    .clk             (clk),
    .por             (por),
    .rst             (rst),
    .reg_rdata       (reg_rdata),
    .xtal_tick       (xtal_tick),
    .bus_tick        (bus_tick),
    .gpio_dout       (gpio_dout),
    .gpio_ddr        (gpio_ddr),
    .pin_out         (pin_out),
    .pin_oe          (pin_oe),
    .tbm_prescale_en (tbm_prescale_en),
    .periph_en       (periph_en),
    .clk_div         (div_clk)
);

// File: tb/clkout_gen_bench.sv
module clkout_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {cfg value, half-period in strobes}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h50, 4'd1}, {8'h20, 4'd2}, {8'h70, 4'd4},
        {8'h10, 4'd1}, {8'h60, 4'd2}, {8'h30, 4'd4}
    };

    logic       clk = 1'b0;
    logic       por = 1'b1, rst = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       xtal_tick = 1'b0, bus_tick = 1'b0;
    logic       gpio_dout = 1'b0, gpio_ddr = 1'b0;
    logic       pin_out, pin_oe, periph_en, tbm_prescale_en;
    int         n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkout_gen u_clkout_gen (
        .clk(clk), .por(por), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xtal_tick(xtal_tick), .bus_tick(bus_tick),
        .gpio_dout(gpio_dout), .gpio_ddr(gpio_ddr), .pin_out(pin_out), .pin_oe(pin_oe),
        .periph_en(periph_en), .tbm_prescale_en(tbm_prescale_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic pulse(input logic xtal);
        @(negedge clk);
        if (xtal) xtal_tick = 1'b1; else bus_tick = 1'b1;
        @(negedge clk);
        xtal_tick = 1'b0; bus_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por = 1'b0;
        idle();
        check("R1 reset value", reg_rdata, 8'h01);
        check("R1 periph_en after por", {7'd0, periph_en}, 8'h00);

        // Table-driven walk over sources and ratios
        gpio_ddr = 1'b1;
        for (int vi = 0; vi < NVEC; vi++) begin
            logic [7:0] cv;
            int         hp;
            logic       xs;
            logic       prev;
            cv = VEC[vi][11:4];
            hp = int'(VEC[vi][3:0]);
            xs = cv[6];
            wr(cv);
            idle();
            check("R8 restart low", {7'd0, pin_out}, 8'h00);
            check("R6 oe follows ddr", {7'd0, pin_oe}, 8'h01);
            for (int k = 1; k <= 8; k++) begin
                prev = pin_out;
                pulse(~xs);
                check("R4 other source ignored", {7'd0, pin_out}, {7'd0, prev});
                pulse(xs);
                check("R5 divided output", {7'd0, pin_out}, {7'd0, 1'((k / hp) % 2)});
            end
        end

        // R8: ratio change while output is high
        wr(8'h70); idle();
        for (int k = 0; k < 4; k++) pulse(1'b1);
        check("R5 /4 high after 4", {7'd0, pin_out}, 8'h01);
        wr(8'h60); idle();
        check("R8 change clears output", {7'd0, pin_out}, 8'h00);
        pulse(1'b1); pulse(1'b1);
        check("R8 restart count /2", {7'd0, pin_out}, 8'h01);

        // R6: clear direction bit gates clock off the pin
        gpio_ddr = 1'b0; idle();
        check("R6 ddr clear gates oe", {7'd0, pin_oe}, 8'h00);

        // R7: field 00 passes port through
        wr(8'h40); gpio_dout = 1'b1; gpio_ddr = 1'b1; idle();
        check("R7 pass dout", {7'd0, pin_out}, 8'h01);
        check("R7 pass ddr", {7'd0, pin_oe}, 8'h01);
        gpio_dout = 1'b0;
        pulse(1'b1); pulse(1'b0);
        check("R7 ticks ignored", {6'd0, pin_out, pin_oe}, 8'h01);
        gpio_ddr = 1'b0; idle();
        check("R7 pass ddr low", {7'd0, pin_oe}, 8'h00);

        // R9: side outputs
        wr(8'h0C);
        check("R9 tbm and periph", {6'd0, periph_en, tbm_prescale_en}, 8'h03);
        wr(8'h00);
        check("R9 tbm and periph cleared", {6'd0, periph_en, tbm_prescale_en}, 8'h00);

        // R3: bit 7 unimplemented
        wr(8'hFF);
        check("R3 readback", reg_rdata, 8'h7F);

        // R2: general reset keeps the power-on-only bit
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R2 general reset", reg_rdata, 8'h09);
        check("R2 periph_en kept", {7'd0, periph_en}, 8'h01);

        // R1: power-on reset clears everything
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        check("R1 por clears all", reg_rdata, 8'h01);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule